// File: doc/BRIEF.md
# Chainable Serial Register Slave for a Digital Potentiometer

This block is the serial-side control logic of a 256-step digital potentiometer. An SPI master writes and reads a small register set through it: a volatile wiper register whose value drives the 8-bit `wiper_code` output, a non-volatile power-up value (modelled here as a register), fourteen general purpose bytes and a control byte. The control byte's top bit decides whether address zero reaches the volatile wiper or the stored power-up value.

Every command is a 16-bit frame: an instruction byte, then a data byte. Commands take effect only when chip select is released. A read is latched at that point and answered in the following chip-select window. The serial output is the input delayed by exactly 16 clocks when no answer is pending. Because of this, several devices can sit in series on one chip select, and each keeps the last frame that reached it. All serial pins are sampled by the block's system clock, so the serial clock must be several times slower than `clk`.

Top module: `spi_chain_pot`

## Requirements
- R1: After reset, `wiper_code` and the stored power-up value both equal parameter `IVR_INIT` (default 8'h80), and the control byte reads 8'h00.
- R2: The instruction byte holds an opcode in bits [7:5] and an address in bits [4:0]. Opcode 3'b000 is no-operation, 3'b001 is read, 3'b010 is write. Every other opcode, and no-operation, leaves all registers unchanged.
- R3: A command runs only on the rising edge of chip select, and only when the number of serial clocks in that window is a non-zero multiple of 16. Any other count discards the window, and no register changes.
- R4: With control bit 7 at 1, a write to address 5'h00 sets only the wiper, and a read of 5'h00 returns the wiper. The stored power-up value is untouched.
- R5: With control bit 7 at 0, a write to address 5'h00 sets the stored power-up value and copies the same byte into the wiper. A read of 5'h00 returns the stored power-up value.
- R6: Reading the stored power-up value leaves the wiper unchanged, even when the two differ.
- R7: Addresses 5'h01 to 5'h0E are general purpose bytes and 5'h10 is the control byte; all of these read back what was written. Writes to any other address except 5'h00 are ignored, and reads of them return 8'h00.
- R8: A read latched at one chip-select rise is answered in the next window. The first byte shifted out is the read instruction byte {3'b001, address}, and the second byte is the register's value.
- R9: With no answer pending, each bit entering `spi_mosi` leaves `spi_miso` 16 serial clocks later, MSB first. In mode 0, input is sampled on the serial clock's rising edge and output changes on its falling edge.
- R10: When a window carries more than one frame, only the last 16 bits received are executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out, also feeds the next device in a chain |
| wiper_code | output | 8 | Current wiper position |

## Verification
The embedded properties assume serial edges that are well apart in system clocks. They assume chip select never moves in the same system cycle as a serial clock edge, and that data in is stable around each rising serial edge. The bench keeps within these limits. It drives every serial level change on a falling system edge and holds each serial half period for eight system clocks. It leaves a half period between chip select changes and clock edges, and it gaps successive windows by ten system clocks.

// File: rtl/spi_pot_pkg.sv
package spi_pot_pkg;
   localparam int OPC_W   = 3;
   localparam int ADDR_W  = 5;
   localparam int DATA_W  = 8;
   localparam int FRAME_W = OPC_W + ADDR_W + DATA_W;

   typedef enum logic [OPC_W-1:0] {
      OPC_NOP   = 3'd0,
      OPC_READ  = 3'd1,
      OPC_WRITE = 3'd2
   } opcode_e;

   localparam logic [ADDR_W-1:0] ADDR_WIPER = 5'h00;
   localparam logic [ADDR_W-1:0] ADDR_CTRL  = 5'h10;

   typedef struct packed {
      logic [OPC_W-1:0]  opc;
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] data;
   } frame_t;
endpackage

// File: rtl/spi_pot_sync.sv
module spi_pot_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              last;

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_pot_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RESET_VAL}};
         last  <= RESET_VAL;
      end else begin
         chain <= {chain[STAGES-2:0], d_in};
         last  <= chain[STAGES-1];
      end
   end

   assign q    = chain[STAGES-1];
   assign rise = q & ~last;
   assign fall = ~q & last;
endmodule

// File: rtl/spi_pot_shifter.sv
module spi_pot_shifter
   import spi_pot_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_n_s,
   input  logic               cs_fall,
   input  logic               cs_rise,
   input  logic               sck_rise,
   input  logic               sck_fall,
   input  logic               mosi_s,
   input  logic               load_en,
   input  logic [FRAME_W-1:0] load_word,
   output logic [FRAME_W-1:0] frame,
   output logic               cmd_stb,
   output logic               miso
);
   localparam int CNT_W = $clog2(FRAME_W);

   logic [FRAME_W-1:0] shreg;
   logic [CNT_W-1:0]   bit_cnt;
   logic               seen_full;
   logic               shift_en;

   if ((1 << CNT_W) != FRAME_W) begin : g_bad_frame
      $error("spi_pot_shifter: frame width must be a power of two");
   end

   assign shift_en = sck_rise & ~cs_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         bit_cnt   <= '0;
         seen_full <= 1'b0;
         miso      <= 1'b0;
         cmd_stb   <= 1'b0;
      end else begin
         cmd_stb <= cs_rise & seen_full & (bit_cnt == '0);
         if (cs_fall) begin
            bit_cnt   <= '0;
            seen_full <= 1'b0;
            if (load_en) begin
               shreg <= load_word;
               miso  <= load_word[FRAME_W-1];
            end else begin
               miso  <= shreg[FRAME_W-1];
            end
         end else if (shift_en) begin
            shreg   <= {shreg[FRAME_W-2:0], mosi_s};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CNT_W'(FRAME_W - 1)) seen_full <= 1'b1;
         end else if (sck_fall && !cs_n_s) begin
            miso <= shreg[FRAME_W-1];
         end
      end
   end

   assign frame = shreg;

   assert_discard_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && bit_cnt != '0) |=> !cmd_stb);
   assert_no_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_rise |=> !cmd_stb);
   assert_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !cs_fall) |=> frame[FRAME_W-1:1] == $past(frame[FRAME_W-2:0]));
   assert_miso_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!sck_fall && !cs_fall) |=> $stable(miso));
endmodule

// File: rtl/spi_pot_regs.sv
module spi_pot_regs
   import spi_pot_pkg::*;
#(
   parameter int                NUM_GPR  = 14,
   parameter logic [DATA_W-1:0] IVR_INIT = 8'h80
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_stb,
   input  logic [FRAME_W-1:0] frame,
   input  logic               cs_fall,
   output logic [DATA_W-1:0]  wiper,
   output logic               load_en,
   output logic [FRAME_W-1:0] load_word
);
   localparam int LAST_GPR = NUM_GPR;

   frame_t              fr;
   logic                wr_hit;
   logic                rd_hit;
   logic [DATA_W-1:0]   ctrl_q;
   logic [DATA_W-1:0]   ivr_q;
   logic [DATA_W-1:0]   wiper_q;
   logic [DATA_W-1:0]   gpr_q [NUM_GPR];
   logic                pend_q;
   logic [ADDR_W-1:0]   pend_addr;
   logic [DATA_W-1:0]   rd_data;

   if (NUM_GPR < 1 || LAST_GPR >= int'(ADDR_CTRL)) begin : g_bad_gpr
      $error("spi_pot_regs: NUM_GPR must leave room below the control address");
   end

   assign fr     = frame_t'(frame);
   assign wr_hit = cmd_stb && (fr.opc == OPC_WRITE);
   assign rd_hit = cmd_stb && (fr.opc == OPC_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         ivr_q     <= IVR_INIT;
         wiper_q   <= IVR_INIT;
         pend_q    <= 1'b0;
         pend_addr <= '0;
      end else begin
         if (cs_fall) pend_q <= 1'b0;
         if (rd_hit) begin
            pend_q    <= 1'b1;
            pend_addr <= fr.addr;
         end
         if (wr_hit && fr.addr == ADDR_WIPER) begin
            wiper_q <= fr.data;
            if (!ctrl_q[DATA_W-1]) ivr_q <= fr.data;
         end
         if (wr_hit && fr.addr == ADDR_CTRL) ctrl_q <= fr.data;
      end
   end

   for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            gpr_q[g] <= '0;
         else if (wr_hit && fr.addr == ADDR_W'(g + 1))
            gpr_q[g] <= fr.data;
      end
   end

   always_comb begin
      rd_data = '0;
      if (pend_addr == ADDR_WIPER)
         rd_data = ctrl_q[DATA_W-1] ? wiper_q : ivr_q;
      else if (pend_addr == ADDR_CTRL)
         rd_data = ctrl_q;
      for (int i = 0; i < NUM_GPR; i++)
         if (pend_addr == ADDR_W'(i + 1)) rd_data = gpr_q[i];
   end

   assign load_en   = pend_q;
   assign load_word = {OPC_READ, pend_addr, rd_data};
   assign wiper     = wiper_q;

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_stb |=> $stable(wiper) && $stable(ivr_q) && $stable(ctrl_q));
   assert_ivr_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb && fr.opc == OPC_WRITE && fr.addr == ADDR_WIPER && ctrl_q[DATA_W-1])
      |=> $stable(ivr_q));
   assert_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb && fr.opc == OPC_WRITE && fr.addr == ADDR_WIPER && !ctrl_q[DATA_W-1])
      |=> wiper == ivr_q);
   assert_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb && fr.opc != OPC_WRITE) |=> $stable(wiper) && $stable(ivr_q));
   assert_echo_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |=> load_en);
endmodule

// File: rtl/spi_chain_pot.sv
module spi_chain_pot
   import spi_pot_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter int                NUM_GPR     = 14,
   parameter logic [DATA_W-1:0] IVR_INIT    = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic [DATA_W-1:0] wiper_code
);
   logic               sck_s, sck_rise, sck_fall;
   logic               cs_s, cs_rise, cs_fall;
   logic               mosi_s, mosi_rise_unused, mosi_fall_unused;
   logic [FRAME_W-1:0] frame, load_word;
   logic               cmd_stb, load_en;

   spi_pot_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sck (
      .clk(clk), .rst_n(rst_n), .d_in(spi_sclk),
      .q(sck_s), .rise(sck_rise), .fall(sck_fall));

   spi_pot_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .d_in(spi_cs_n),
      .q(cs_s), .rise(cs_rise), .fall(cs_fall));

   spi_pot_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_mosi (
      .clk(clk), .rst_n(rst_n), .d_in(spi_mosi),
      .q(mosi_s), .rise(mosi_rise_unused), .fall(mosi_fall_unused));

   spi_pot_shifter u_shift (
      .clk(clk), .rst_n(rst_n),
      .cs_n_s(cs_s), .cs_fall(cs_fall), .cs_rise(cs_rise),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
      .load_en(load_en), .load_word(load_word),
      .frame(frame), .cmd_stb(cmd_stb), .miso(spi_miso));

   spi_pot_regs #(.NUM_GPR(NUM_GPR), .IVR_INIT(IVR_INIT)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cmd_stb(cmd_stb), .frame(frame), .cs_fall(cs_fall),
      .wiper(wiper_code), .load_en(load_en), .load_word(load_word));

   assert_sck_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_s && !cs_fall) |=> $stable(spi_miso));
endmodule

// File: tb/spi_chain_pot_test.sv
module spi_chain_pot_test;
   localparam int CLK_P = 10;
   localparam int HALF  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic miso_a, miso_b;
   logic [7:0] wiper_a, wiper_b;
   int checks = 0, failures = 0;
   logic [7:0] gexp [16];

   always #(CLK_P/2) clk = ~clk;

   spi_chain_pot uut (.clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
      .spi_mosi(mosi), .spi_miso(miso_a), .wiper_code(wiper_a));
   spi_chain_pot uut_next (.clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
      .spi_mosi(miso_a), .spi_miso(miso_b), .wiper_code(wiper_b));

   function automatic logic [15:0] mk(input logic [2:0] opc, input logic [4:0] a,
                                      input logic [7:0] d);
      return {opc, a, d};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input logic [31:0] tx, input int nbits, output logic [31:0] rx);
      rx = '0;
      cs_n = 1'b0;
      for (int i = nbits - 1; i >= 0; i--) begin
         mosi = tx[i];
         wt(HALF);
         rx = {rx[30:0], miso_a};
         sclk = 1'b1;
         wt(HALF);
         sclk = 1'b0;
      end
      wt(HALF);
      cs_n = 1'b1;
      wt(10);
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      logic [31:0] rx;
      xfer({16'h0, mk(3'd2, a, d)}, 16, rx);
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] d);
      logic [31:0] rx;
      xfer({16'h0, mk(3'd1, a, 8'h00)}, 16, rx);
      xfer({16'h0, mk(3'd0, 5'h00, 8'h00)}, 16, rx);
      chk("R8 echo", rx[15:8], {3'd1, a});
      d = rx[7:0];
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic [31:0] rx;
      wt(5);
      rst_n = 1'b1;
      wt(5);
      chk("R1 wiper", wiper_a, 8'h80);
      rd(5'h10, d); chk("R1 ctrl", d, 8'h00);
      rd(5'h00, d); chk("R1 ivr", d, 8'h80);

      wr(5'h00, 8'h33);
      chk("R5 wiper copy", wiper_a, 8'h33);
      rd(5'h00, d); chk("R5 ivr", d, 8'h33);

      wr(5'h10, 8'h80);
      rd(5'h10, d); chk("R7 ctrl", d, 8'h80);
      wr(5'h00, 8'h77);
      chk("R4 wiper", wiper_a, 8'h77);
      rd(5'h00, d); chk("R4 read wiper", d, 8'h77);
      wr(5'h10, 8'h00);
      rd(5'h00, d); chk("R4 ivr kept", d, 8'h33);
      chk("R6 wiper after ivr read", wiper_a, 8'h77);

      for (int op = 0; op < 8; op++) begin
         if (op == 1 || op == 2) continue;
         xfer({16'h0, mk(3'(op), 5'h00, 8'hEE)}, 16, rx);
         chk("R2 opcode ignored", wiper_a, 8'h77);
      end
      rd(5'h00, d); chk("R2 ivr kept", d, 8'h33);

      for (int a = 1; a <= 14; a++) begin
         gexp[a] = 8'(a * 7 + 3);
         wr(5'(a), gexp[a]);
      end
      for (int a = 17; a < 32; a++) wr(5'(a), 8'hFF);
      wr(5'h0F, 8'hFF);
      for (int a = 1; a <= 14; a++) begin
         rd(5'(a), d); chk("R7 gpr", d, gexp[a]);
      end
      rd(5'h0F, d); chk("R7 hole", d, 8'h00);
      for (int a = 17; a < 32; a += 7) begin
         rd(5'(a), d); chk("R7 unmapped", d, 8'h00);
      end
      rd(5'h10, d); chk("R7 ctrl kept", d, 8'h00);

      xfer({16'h0, mk(3'd2, 5'h00, 8'h01)}, 15, rx);
      chk("R3 15 bits", wiper_a, 8'h77);
      xfer({15'h0, 1'b0, mk(3'd2, 5'h00, 8'h02)}, 17, rx);
      chk("R3 17 bits", wiper_a, 8'h77);
      xfer(32'h0, 0, rx);
      chk("R3 empty", wiper_a, 8'h77);

      xfer({mk(3'd2, 5'h01, 8'h11), mk(3'd2, 5'h00, 8'h99)}, 32, rx);
      chk("R10 last frame", wiper_a, 8'h99);
      rd(5'h01, d); chk("R10 first frame passed", d, gexp[1]);

      wr(5'h02, 8'h00);
      xfer({16'h1234, 16'h0000}, 32, rx);
      chk("R9 pass-through", rx[15:0], 32'h1234);
      xfer({mk(3'd2, 5'h00, 8'hC4), mk(3'd2, 5'h00, 8'h3B)}, 32, rx);
      chk("R9 chain near", wiper_a, 8'h3B);
      chk("R9 chain far", wiper_b, 8'hC4);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule